// File: doc/BRIEF.md
# Level-Capture Interrupt Bank

This block watches a bank of input-only channels for a chosen active level and turns each occurrence into a sticky pending flag. It is meant for signals that can appear while the register clock is gated off. Each channel has a storage cell that is set asynchronously, straight from the pin, so a pulse that lasts less than one clock period is still recorded. Two flip-flops carry the stored flag into the register clock domain. The flag then shows up in a raw status register and, once enabled, in a masked status register and on a single combined interrupt line.

Software uses a small word-addressed register file to set up the bank:
- a per-channel enable;
- a polarity, where a 0 bit means the channel is active-high;
- a per-channel mode that selects between sticky capture and live level follow.

Pending flags are released by writing ones to a clear register. If the active level is still present when a clear arrives, the flag sets again at once, so a level that has not gone away cannot be lost.

Top module: `lvl_latch_irq_bank`

## Requirements
- R1: After synchronous reset, enable (0x00), polarity (0x10) and mode (0x14) read as zero. Raw status (0x04) and masked status (0x08) read as zero while the pins are low, and `irq_out` is 0.
- R2: In sticky mode (mode bit 0), an active level on a channel sets its flag with no register clock edge needed. A pulse narrower than one clock period, placed between edges, is still recorded in raw status bit i.
- R3: A channel is active when `pin_in[i] XOR polarity[i]` is 1. Polarity bit 0 selects active-high and polarity bit 1 selects active-low.
- R4: In sticky mode, a recorded flag stays set after the input returns to the inactive level, until it is cleared.
- R5: Writing 1 to bit i of the clear register (0x0C) releases flag i. Bits written as 0 leave their flags unchanged. Reads of 0x0C return zero.
- R6: A clear issued while channel i is still at its active level leaves flag i set.
- R7: With mode bit i set to 1, raw status bit i follows the synchronized active level and drops once the input goes inactive, with no clear needed.
- R8: Masked status (0x08) reads as raw status ANDed with enable (0x00).
- R9: `irq_out` is the OR of the masked status bits. An active pulse placed between edges E0 and E1 raises `irq_out` after edge E3, and not before.
- R10: Register bits at or above the channel count read as zero. Writes to raw status and masked status have no effect. Addresses other than the six listed read as zero.
- R11: `bus_rdata` presents the addressed register one clock after `bus_rd` is sampled high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_CH | Monitored channel inputs, may change at any time |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_out | output | 1 | Combined interrupt, OR of the masked flags |

## Verification
A storage cell that fails to set on a short pulse, or that clears while its input is still active, shows up as a wrong bit in raw status. This is visible on the first read made three edges after the event, and also as a missing or early `irq_out` edge. A polarity or enable bit that lands in the wrong lane gives a masked status that differs from raw AND enable for that channel, and this is seen on the next masked read. The bench therefore sweeps every 8-bit event pattern under several polarity words, and pins down the exact interrupt latency, the clear-while-active case and the follow mode separately.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_RAW  = 3'd1,
    SEL_MSK  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_POL  = 3'd4,
    SEL_MODE = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned SEL_BITS = 3;

  // Word-aligned byte address decode; upper bits must be zero.
  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[WORD_LSB-1:0] == '0 && a[31:WORD_LSB+SEL_BITS] == '0) begin
      case (a[WORD_LSB+SEL_BITS-1:WORD_LSB])
        3'd0: s = SEL_EN;
        3'd1: s = SEL_RAW;
        3'd2: s = SEL_MSK;
        3'd3: s = SEL_CLR;
        3'd4: s = SEL_POL;
        3'd5: s = SEL_MODE;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/lvl_latch_cell.sv
// One capture cell: set asynchronously by the active level, released
// at a clock edge by reset or a clear pulse. Set dominates release.
module lvl_latch_cell (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic clr_i,
  output logic hold_o
);

  always_ff @(posedge clk or posedge act_i) begin
    if (act_i) begin
      hold_o <= 1'b1;
    end else if (rst || clr_i) begin
      hold_o <= 1'b0;
    end
  end

endmodule

// File: rtl/lvl_sync.sv
// Multi-stage synchronizer into the register clock domain.
module lvl_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lvl_irq_regs.sv
// Register file: configuration, write-one-to-clear pulses and a
// registered read mux.
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [N_CH-1:0] raw_i,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] pol_o,
  output logic [N_CH-1:0] mode_o,
  output logic [N_CH-1:0] clr_o,
  output logic [DW-1:0]   bus_rdata
);

  localparam int unsigned PAD = DW - N_CH;

  reg_sel_e        sel;
  logic [31:0]     addr_ext;
  logic [N_CH-1:0] wbits;
  logic [N_CH-1:0] rd_bits;

  assign addr_ext = 32'(bus_addr);
  assign sel      = decode_addr(addr_ext);
  assign wbits    = bus_wdata[N_CH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      pol_o  <= '0;
      mode_o <= '0;
      clr_o  <= '0;
    end else begin
      clr_o <= '0;
      if (bus_wr) begin
        case (sel)
          SEL_EN:   en_o   <= wbits;
          SEL_POL:  pol_o  <= wbits;
          SEL_MODE: mode_o <= wbits;
          SEL_CLR:  clr_o  <= wbits;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_EN:   rd_bits = en_o;
      SEL_RAW:  rd_bits = raw_i;
      SEL_MSK:  rd_bits = raw_i & en_o;
      SEL_POL:  rd_bits = pol_o;
      SEL_MODE: rd_bits = mode_o;
      default:  rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= {{PAD{1'b0}}, rd_bits};
    end
  end

endmodule

// File: rtl/lvl_latch_irq_bank.sv
module lvl_latch_irq_bank #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] pin_in,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_out
);

  logic [N_CH-1:0] en_q, pol_q, mode_q, clr_q;
  logic [N_CH-1:0] act_lvl, hold_q, sync_d, raw_q;

  assign act_lvl = pin_in ^ pol_q;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      lvl_latch_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act_lvl[i]),
        .clr_i  (clr_q[i]),
        .hold_o (hold_q[i])
      );
      assign sync_d[i] = mode_q[i] ? act_lvl[i] : hold_q[i];
    end
  endgenerate

  lvl_sync #(.W(N_CH), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sync_d),
    .q_o (raw_q)
  );

  lvl_irq_regs #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_i     (raw_q),
    .en_o      (en_q),
    .pol_o     (pol_q),
    .mode_o    (mode_q),
    .clr_o     (clr_q),
    .bus_rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(raw_q & en_q);
  end

endmodule

// File: rtl/lvl_latch_irq_bank_chk.sv
module lvl_latch_irq_bank_chk
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic            irq_out,
  input logic [N_CH-1:0] raw_q,
  input logic [N_CH-1:0] en_q,
  input logic [N_CH-1:0] hold_q,
  input logic [N_CH-1:0] clr_q
);

  reg_sel_e chk_sel;
  assign chk_sel = decode_addr(32'(bus_addr));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq_out);

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|(raw_q & en_q))));

  // R4
  hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(hold_q) & ~$past(clr_q) & ~hold_q) == '0));

  // R5
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(chk_sel) == SEL_CLR && !$past(rst)) |-> (bus_rdata == '0));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(chk_sel) == SEL_NONE && !$past(rst)) |-> (bus_rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_rd) && !$past(rst)) |-> $stable(bus_rdata));

endmodule

bind lvl_latch_irq_bank lvl_latch_irq_bank_chk #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .raw_q     (raw_q),
  .en_q      (en_q),
  .hold_q    (hold_q),
  .clr_q     (clr_q)
);

// File: tb/lvl_latch_irq_bank_tb_top.sv
`timescale 1ns/1ps
module lvl_latch_irq_bank_tb_top;

  localparam int unsigned N_CH = 8;
  localparam int unsigned AW   = 5;
  localparam int unsigned DW   = 32;

  localparam logic [AW-1:0] A_EN   = 5'h00;
  localparam logic [AW-1:0] A_RAW  = 5'h04;
  localparam logic [AW-1:0] A_MSK  = 5'h08;
  localparam logic [AW-1:0] A_CLR  = 5'h0C;
  localparam logic [AW-1:0] A_POL  = 5'h10;
  localparam logic [AW-1:0] A_MODE = 5'h14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N_CH-1:0] pin_in = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lvl_latch_irq_bank #(.N_CH(N_CH), .AW(AW), .DW(DW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Narrow pulse between two edges: no register clock edge during it.
  task automatic glitch(input logic [N_CH-1:0] base, input logic [N_CH-1:0] flip);
    @(negedge clk);
    #0.5 pin_in = base ^ flip;
    #1.0 pin_in = base;
  endtask

  initial begin : watchdog
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] v;
    logic [N_CH-1:0] pols [4];
    pols[0] = 8'h00; pols[1] = 8'hFF; pols[2] = 8'hA5; pols[3] = 8'h3C;

    idle(4);
    @(negedge clk) rst = 1'b0;
    idle(1);

    // R1 reset state
    rd_reg(A_EN, v);   check("R1 enable", v, 0);
    rd_reg(A_POL, v);  check("R1 polarity", v, 0);
    rd_reg(A_MODE, v); check("R1 mode", v, 0);
    rd_reg(A_RAW, v);  check("R1 raw", v, 0);
    rd_reg(A_MSK, v);  check("R1 masked", v, 0);
    check("R1 irq", {31'b0, irq_out}, 0);

    // R10 register width, read-only and unmapped addresses
    wr_reg(A_EN, 32'hFFFF_FFFF);
    rd_reg(A_EN, v);  check("R10 enable upper bits", v, 32'hFF);
    wr_reg(A_RAW, 32'hFF);
    rd_reg(A_RAW, v); check("R10 raw write ignored", v, 0);
    wr_reg(A_MSK, 32'hFF);
    rd_reg(A_MSK, v); check("R10 masked write ignored", v, 0);
    rd_reg(5'h18, v); check("R10 unmapped 0x18", v, 0);
    rd_reg(5'h02, v); check("R10 unaligned", v, 0);
    wr_reg(A_EN, 0);

    // R11 read data holds between reads
    wr_reg(A_POL, 32'h5A);
    rd_reg(A_POL, v); check("R11 read value", v, 32'h5A);
    idle(3);
    check("R11 held", bus_rdata, 32'h5A);
    wr_reg(A_POL, 0);
    idle(4);

    // R2 R3 R4 R8 R9 sweep over patterns and polarities
    for (int pi = 0; pi < 4; pi++) begin
      for (int p = 0; p < 256; p++) begin
        logic [N_CH-1:0] pol, pat, en;
        pol = pols[pi];
        pat = 8'(p);
        en  = 8'(p * 37 + pi * 11);
        wr_reg(A_POL, 32'(pol));
        @(negedge clk) pin_in = pol;
        wr_reg(A_EN, 32'(en));
        idle(2);
        wr_reg(A_CLR, 32'hFF);
        idle(5);
        glitch(pol, pat);
        idle(4);
        rd_reg(A_RAW, v);
        check("R2 R3 R4 raw capture", v, 32'(pat));
        rd_reg(A_MSK, v);
        check("R8 masked", v, 32'(pat & en));
        check("R9 irq", {31'b0, irq_out}, {31'b0, |(pat & en)});
      end
    end

    // R9 exact latency
    wr_reg(A_POL, 0);
    @(negedge clk) pin_in = '0;
    wr_reg(A_EN, 32'h01);
    wr_reg(A_CLR, 32'hFF);
    idle(6);
    @(negedge clk);
    #0.5 pin_in = 8'h01;
    #1.0 pin_in = 8'h00;
    @(posedge clk); #1 check("R9 irq after E1", {31'b0, irq_out}, 0);
    @(posedge clk); #1 check("R9 irq after E2", {31'b0, irq_out}, 0);
    @(posedge clk); #1 check("R9 irq after E3", {31'b0, irq_out}, 1);

    // R6 clear while active, R5 partial clear
    wr_reg(A_CLR, 32'hFF);
    @(negedge clk) pin_in = 8'h0F;
    idle(4);
    wr_reg(A_CLR, 32'hFF);
    idle(5);
    rd_reg(A_RAW, v); check("R6 clear while active", v, 32'h0F);
    @(negedge clk) pin_in = 8'h00;
    idle(4);
    rd_reg(A_RAW, v); check("R4 held after release", v, 32'h0F);
    wr_reg(A_CLR, 32'h03);
    idle(5);
    rd_reg(A_RAW, v); check("R5 partial clear", v, 32'h0C);
    rd_reg(A_CLR, v); check("R5 clear reads zero", v, 0);
    wr_reg(A_CLR, 32'h0C);
    idle(5);
    rd_reg(A_RAW, v); check("R5 full clear", v, 0);

    // R7 follow mode
    wr_reg(A_MODE, 32'hF0);
    @(negedge clk) pin_in = 8'h55;
    idle(4);
    rd_reg(A_RAW, v); check("R7 follow active", v, 32'h55);
    @(negedge clk) pin_in = 8'h00;
    idle(4);
    rd_reg(A_RAW, v); check("R7 follow released", v, 32'h05);
    wr_reg(A_MODE, 0);
    wr_reg(A_CLR, 32'hFF);
    idle(5);
    rd_reg(A_RAW, v); check("R5 clear after follow", v, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule